// File: doc/BRIEF.md
# Programmable framed serial I/O port

This block is a general-purpose synchronous serial port. A write to its data register starts one transfer. The port shifts a word out on `sdo`, captures a word from `sdi`, drives a generated serial clock `sck`, and drives a frame strobe `frm`. All timing comes from a base tick. The tick is the system clock halved and then divided by a programmed factor. A base counter, cleared when the transfer starts, counts these ticks.

Every event in a transfer sits at a programmed base-counter value:

- the first data bit starts at the delay count;
- each bit spans two ticks, with `sck` low for the first and high for the second;
- the frame strobe is active from the frame-start value up to, but not including, the frame-end value.

A polarity bit selects the active level of the frame strobe. A mask bit can suppress the final `sck` pulse for devices that need it. When the word completes, `busy` drops, `done` pulses for one cycle and `rx_data` holds the received word.

Software-style control is written through `cfg_wr`, which loads all configuration fields at once. `data_wr` loads the transmit word and starts the transfer.

Top module: `fsio_port`

## Requirements
- R1: After reset, `busy`, `done`, `sck`, `sdo` and `rx_data` are 0. The configuration is all zeros, so polarity is 0 (active-low) and `frm` idles at 1.
- R2: The base tick period is 2*n system clocks, where n is `cfg_div`. When `data_wr` is accepted at clock edge E0, the base counter b is floor(m/(2n)) after edge E0+m.
- R3: Bit k (k = 0..L-1) has its low half at b = delay+2k and its high half at b = delay+2k+1. `sck` is 1 only in high halves and is 0 at all other times, including idle.
- R4: The word length is L = `cfg_len_m1`+1, from 1 to 16. `sdo` sends `data_in[L-1:0]` MSB first; bit k carries `data_in[L-1-k]`. `sdo` shows `data_in[L-1]` while b < delay, and is 0 while idle.
- R5: `sdi` is sampled at the end of each low half, which is the rising edge of `sck`. After the transfer, `rx_data[L-1:0]` holds the received bits with the first received bit in position L-1, and `rx_data[15:L]` is 0. `rx_data` is cleared when a transfer starts.
- R6: While busy, the frame is active when `cfg_frm_on` <= b < `cfg_frm_off`. `frm` equals `cfg_frm_pol` when active and its inverse otherwise. When `cfg_frm_pol` is 1 the frame is active-high; when 0 it is active-low. While idle, `frm` is inactive.
- R7: When `cfg_lcm` is 1, `sck` stays 0 during the high half of the last bit. The last bit is still sampled.
- R8: At the tick that ends the last high half (b = delay+2L), `busy` falls and `done` is 1 for exactly one cycle.
- R9: `data_wr` or `cfg_wr` while busy is ignored. The running transfer continues with its original word and configuration.
- R10: A `cfg_div` of 0 behaves as 1, giving a base tick every 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load all configuration fields (accepted when idle) |
| cfg_div | input | 8 | Divider factor n (0 treated as 1) |
| cfg_delay | input | 8 | Base-counter value at which the first bit starts |
| cfg_len_m1 | input | 4 | Word length minus one |
| cfg_frm_on | input | 8 | Base-counter value at which the frame becomes active |
| cfg_frm_off | input | 8 | Base-counter value at which the frame becomes inactive |
| cfg_frm_pol | input | 1 | Frame active level (1 = high) |
| cfg_lcm | input | 1 | Suppress the final sck pulse |
| data_wr | input | 1 | Write the transmit word and start (accepted when idle) |
| data_in | input | 16 | Transmit word, right-aligned |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sck | output | 1 | Serial clock, idles low |
| frm | output | 1 | Frame strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 16 | Received word, right-aligned, upper bits zero |

## Verification
The hardest situation to reach is the interplay of several settings in one transfer. That means a divider of 0, a one-bit or sixteen-bit word, and frame edges placed before, inside and after the data window, all at once. Add an ignored write arriving mid-transfer. Each of these changes only a few cycles at the pins.

The stimulus runs directed transfers that pin each extreme. It then runs random transfers with a fixed seed, drawing divider, delay, length, frame points, polarity and mask. Every cycle the bench predicts `sck`, `sdo`, `frm`, `busy` and `done` from the base-counter arithmetic. It drives `sdi` with a pattern word only during low halves, so misaligned sampling shows in `rx_data`.

// File: rtl/fsio_pkg.sv
// Package: shared widths and the configuration record of the framed serial port.
// Assumes the base counter must reach delay_max + 2*len_max without wrap.
package fsio_pkg;
    localparam int DIV_W  = 8;
    localparam int CNT_W  = 8;
    localparam int LEN_W  = 4;
    localparam int DATA_W = 1 << LEN_W;
    localparam int BC_W   = ((CNT_W > LEN_W + 1) ? CNT_W : LEN_W + 1) + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] delay;
        logic [LEN_W-1:0] len_m1;
        logic [CNT_W-1:0] frm_on;
        logic [CNT_W-1:0] frm_off;
        logic             pol;
        logic             lcm;
    } fsio_cfg_t;
endpackage

// File: rtl/fsio_tick_gen.sv
// Base tick generator: issues a one-cycle tick every 2*n clocks while run is high.
// Assumes: restart aligns the phase so the first tick lands 2*n clocks after it; n = 0 acts as 1.
module fsio_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] n_eff;
    logic [DIV_W:0]   lim;
    logic [DIV_W:0]   pcnt;

    // Terminal count 2*n-1, with zero mapped to one.
    always_comb begin
        n_eff = (div == '0) ? DIV_W'(1) : div;
        lim   = {n_eff - DIV_W'(1), 1'b1};
        tick  = run && !restart && (pcnt == lim);
    end

    // Prescale counter, cleared on restart or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart || !run || pcnt == lim)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    // R2: a tick never repeats on the next clock, since the period is at least two.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/fsio_seq.sv
// Transfer sequencer: owns the base counter, busy/done, and decodes the bit phase.
// Assumes delay and len_m1 stay constant while busy (the top only loads them when idle).
module fsio_seq
    import fsio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] delay,
    input  logic [LEN_W-1:0] len_m1,
    output logic             busy,
    output logic             done,
    output logic [BC_W-1:0]  bcnt,
    output logic             in_win,
    output logic             hi_half,
    output logic             last,
    output logic             samp_en,
    output logic             shift_en
);
    logic [BC_W-1:0] rel;
    logic [BC_W-1:0] win_len;
    logic            fin;

    // Position of the counter inside the data window.
    always_comb begin
        win_len  = (BC_W'(len_m1) + BC_W'(1)) << 1;
        rel      = bcnt - BC_W'(delay);
        in_win   = busy && (bcnt >= BC_W'(delay)) && (rel < win_len);
        hi_half  = rel[0];
        last     = (rel == win_len - BC_W'(1));
        samp_en  = tick && in_win && !hi_half;
        shift_en = tick && in_win && hi_half && !last;
        fin      = tick && in_win && last;
    end

    // Busy flag, done pulse and base counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            bcnt <= '0;
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            bcnt <= '0;
        end else begin
            done <= fin;
            if (fin)
                busy <= 1'b0;
            if (tick)
                bcnt <= bcnt + 1'b1;
        end
    end

    // R8: completion pulse lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: busy only ends together with a done pulse.
    a_r8_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R2: the base counter moves only on ticks or a new start.
    a_r2_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(bcnt));
endmodule

// File: rtl/fsio_shifter.sv
// Data path: MSB-first transmit shift register and right-aligned receive shift register.
// Assumes len_m1 is stable while busy; start loads the transmit word and clears the receive word.
module fsio_shifter
    import fsio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              samp_en,
    input  logic              shift_en,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] tx_sh;

    // Current output bit is the top bit of the active word.
    always_comb sdo = busy && tx_sh[len_m1];

    // Transmit register: load at start, move left after each high half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (start)
            tx_sh <= data_in;
        else if (shift_en)
            tx_sh <= tx_sh << 1;
    end

    // Receive register: clear at start, shift a sample in at each sck rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_data <= '0;
        else if (start)
            rx_data <= '0;
        else if (samp_en)
            rx_data <= {rx_data[DATA_W-2:0], sdi};
    end

    // R5: while a word is in flight, no bit above the word length is ever set.
    a_r5_rx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((rx_data >> (32'(len_m1) + 1)) == '0));
endmodule

// File: rtl/fsio_frame.sv
// Frame comparator: active while busy and frm_on <= bcnt < frm_off, then polarity applied.
// Assumes frm_on >= frm_off yields no active frame.
module fsio_frame
    import fsio_pkg::*;
(
    input  logic             busy,
    input  logic [BC_W-1:0]  bcnt,
    input  logic [CNT_W-1:0] frm_on,
    input  logic [CNT_W-1:0] frm_off,
    input  logic             pol,
    output logic             frm
);
    logic active;

    // Window compare against the base counter, then output level.
    always_comb begin
        active = busy && (bcnt >= BC_W'(frm_on)) && (bcnt < BC_W'(frm_off));
        frm    = active ? pol : !pol;
    end
endmodule

// File: rtl/fsio_port.sv
// Top of the framed serial port: configuration register, tick generator,
// sequencer, data shifter and frame comparator.
// Assumes one system clock; configuration and data writes are accepted only while idle.
module fsio_port
    import fsio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [CNT_W-1:0]  cfg_delay,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic [CNT_W-1:0]  cfg_frm_on,
    input  logic [CNT_W-1:0]  cfg_frm_off,
    input  logic              cfg_frm_pol,
    input  logic              cfg_lcm,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              sdi,
    output logic              sdo,
    output logic              sck,
    output logic              frm,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    fsio_cfg_t       cfg;
    logic            start;
    logic            tick;
    logic [BC_W-1:0] bcnt;
    logic            in_win;
    logic            hi_half;
    logic            last;
    logic            samp_en;
    logic            shift_en;

    // A data write starts a transfer only when idle.
    always_comb start = data_wr && !busy;

    // Configuration register, frozen during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (cfg_wr && !busy)
            cfg <= '{div: cfg_div, delay: cfg_delay, len_m1: cfg_len_m1,
                     frm_on: cfg_frm_on, frm_off: cfg_frm_off,
                     pol: cfg_frm_pol, lcm: cfg_lcm};
    end

    fsio_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(start),
        .div(cfg.div), .tick(tick)
    );

    fsio_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .delay(cfg.delay), .len_m1(cfg.len_m1),
        .busy(busy), .done(done), .bcnt(bcnt), .in_win(in_win),
        .hi_half(hi_half), .last(last), .samp_en(samp_en), .shift_en(shift_en)
    );

    fsio_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .data_in(data_in), .len_m1(cfg.len_m1),
        .samp_en(samp_en), .shift_en(shift_en), .sdi(sdi),
        .sdo(sdo), .rx_data(rx_data)
    );

    fsio_frame u_frame (
        .busy(busy), .bcnt(bcnt), .frm_on(cfg.frm_on), .frm_off(cfg.frm_off),
        .pol(cfg.pol), .frm(frm)
    );

    // Serial clock high in high halves, except a masked final pulse.
    always_comb sck = in_win && hi_half && !(cfg.lcm && last);

    // R9: configuration cannot change under a running transfer.
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> $stable(cfg));
    // R3: the serial clock is low when a transfer begins and while idle.
    a_r3_sck_low_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !sck);
    a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    // R6: the frame sits at its inactive level while idle.
    a_r6_frame_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (frm == !cfg.pol));
endmodule

// File: tb/fsio_port_tb.sv
// Bench for fsio_port: directed corners plus seeded random transfers, each cycle
// predicted from base-counter arithmetic.
module fsio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic [7:0]  cfg_delay = '0;
    logic [3:0]  cfg_len_m1 = '0;
    logic [7:0]  cfg_frm_on = '0;
    logic [7:0]  cfg_frm_off = '0;
    logic        cfg_frm_pol = 1'b0;
    logic        cfg_lcm = 1'b0;
    logic        data_wr = 1'b0;
    logic [15:0] data_in = '0;
    logic        sdi = 1'b0;
    logic        sdo, sck, frm, busy, done;
    logic [15:0] rx_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fsio_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
        .cfg_delay(cfg_delay), .cfg_len_m1(cfg_len_m1), .cfg_frm_on(cfg_frm_on),
        .cfg_frm_off(cfg_frm_off), .cfg_frm_pol(cfg_frm_pol), .cfg_lcm(cfg_lcm),
        .data_wr(data_wr), .data_in(data_in), .sdi(sdi), .sdo(sdo), .sck(sck),
        .frm(frm), .busy(busy), .done(done), .rx_data(rx_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Expected sck for base count b (R3, R7).
    function automatic bit exp_sck(int b, int d, int len, bit lcm);
        int rel = b - d;
        if (b < d || rel >= 2 * len) return 1'b0;
        if (rel[0] == 1'b0) return 1'b0;
        if (lcm && rel == 2 * len - 1) return 1'b0;
        return 1'b1;
    endfunction

    // Expected sdo for base count b (R4).
    function automatic bit exp_sdo(int b, int d, int len, logic [15:0] w);
        if (b < d) return w[len-1];
        return w[len - 1 - (b - d) / 2];
    endfunction

    // Expected frame level for base count b (R6).
    function automatic bit exp_frm(int b, int on, int off, bit pol);
        bit act = (b >= on) && (b < off);
        return act ? pol : !pol;
    endfunction

    // One full transfer, checked cycle by cycle.
    task automatic xfer(input int n, input int d, input int lm1, input int on,
                        input int off, input bit pol, input bit lcm,
                        input logic [15:0] w, input logic [15:0] pat, input bit poke);
        int len = lm1 + 1;
        int per = 2 * ((n == 0) ? 1 : n);
        int endm = (d + 2 * len) * per;
        logic [15:0] mask = (len == 16) ? 16'hFFFF : ((16'h1 << len) - 16'h1);
        @(negedge clk);
        cfg_div = 8'(n); cfg_delay = 8'(d); cfg_len_m1 = 4'(lm1);
        cfg_frm_on = 8'(on); cfg_frm_off = 8'(off); cfg_frm_pol = pol; cfg_lcm = lcm;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; data_in = w; data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
        for (int m = 0; m <= endm + 1; m++) begin
            int b = m / per;
            int rel = b - d;
            // Drive the pattern bit during low halves, junk otherwise (R5).
            if (b >= d && rel < 2 * len && rel[0] == 1'b0)
                sdi = pat[len - 1 - rel / 2];
            else
                sdi = 1'($urandom);
            if (poke && m == 1) begin
                data_in = ~w; data_wr = 1'b1;
                cfg_wr = 1'b1; cfg_div = 8'(n + 1); cfg_len_m1 = 4'(lm1 ^ 1);
                cfg_frm_pol = !pol; cfg_delay = 8'(d + 3);
            end else if (poke && m == 2) begin
                data_wr = 1'b0; cfg_wr = 1'b0;
            end
            if (m < endm) begin
                chk(poke ? "R9 busy" : "R8 busy", 32'(busy), 1);
                chk("R8 done low", 32'(done), 0);
                chk(lcm ? "R7 sck" : (n == 0 ? "R10 sck" : "R3 sck"),
                    32'(sck), 32'(exp_sck(b, d, len, lcm)));
                chk(poke ? "R9 sdo" : "R4 sdo", 32'(sdo), 32'(exp_sdo(b, d, len, w)));
                chk("R6 frm", 32'(frm), 32'(exp_frm(b, on, off, pol)));
            end else if (m == endm) begin
                chk("R8 busy end", 32'(busy), 0);
                chk("R8 done", 32'(done), 1);
                chk(n == 0 ? "R10 timing" : "R2 timing", 32'(done), 1);
                chk("R5 rx_data", 32'(rx_data), 32'(pat & mask));
                chk("R3 sck idle", 32'(sck), 0);
                chk("R4 sdo idle", 32'(sdo), 0);
                chk("R6 frm idle", 32'(frm), 32'(!pol));
            end else begin
                chk("R8 done one cycle", 32'(done), 0);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state.
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 sck", 32'(sck), 0);
        chk("R1 sdo", 32'(sdo), 0);
        chk("R1 frm", 32'(frm), 1);
        chk("R1 rx_data", 32'(rx_data), 0);
        // Directed corners.
        xfer(1, 0, 7, 0, 16, 1'b1, 1'b0, 16'h00A5, 16'h003C, 1'b0);   // R3 R4 R5 R6 basic
        xfer(0, 2, 0, 1, 4, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b0);    // R10 divider 0, one bit
        xfer(2, 3, 15, 2, 40, 1'b1, 1'b1, 16'hC3A9, 16'h5E71, 1'b0);  // R7 mask, sixteen bits
        xfer(1, 1, 4, 9, 3, 1'b1, 1'b0, 16'h0013, 16'h000B, 1'b0);    // R6 empty frame window
        xfer(3, 4, 5, 0, 200, 1'b0, 1'b1, 16'h002D, 16'h0032, 1'b1);  // R9 writes while busy
        xfer(1, 0, 0, 0, 1, 1'b1, 1'b1, 16'hFFFE, 16'h0001, 1'b0);    // R7 one bit, masked
        // Seeded random transfers.
        for (int i = 0; i < 40; i++) begin
            int n = $urandom_range(0, 4);
            int d = $urandom_range(0, 9);
            int lm1 = $urandom_range(0, 15);
            int top = d + 2 * (lm1 + 1) + 2;
            int on = $urandom_range(0, top);
            int off = $urandom_range(0, top);
            xfer(n, d, lm1, on, off, 1'($urandom), 1'($urandom),
                 16'($urandom), 16'($urandom), 1'(i % 7 == 3));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule